// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a behavioural, synthesizable model of a synchronous static RAM with flow-through reads and a two-bit burst address counter. It has four byte lanes and a small depth set by a parameter. On each rising clock edge it samples three chip selects, two address strobes (a processor strobe and a controller strobe), an advance input and a set of write controls. From these it decides the kind of cycle: deselect, begin-burst read, begin-burst write, continue (advance) or suspend (hold).

Read data for the address registered at an edge appears in the cycle right after that edge. No output pipeline stage is added. The read bus is modelled as a data vector plus a drive-enable flag that stands in for the three-state drivers. The output enable is asynchronous and can only switch off drivers that a read cycle has turned on.

A sleep input puts the block into standby and keeps the memory contents. After sleep is released, a parameterized number of edges pass with all accesses ignored. The block then stays deselected until a strobe starts a new access.

Top module: `fts_sram`

## Requirements
- R1: An access is started by a strobe only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at that edge. A strobed cycle with any other select combination is a deselect.
- R2: `sel2` and `sel3_n` are ignored on edges where neither strobe is active. A burst continues even when they are deasserted.
- R3: After reset, and in the cycle after any deselect, `rdata_en`=0 and `rdata`=0. A deselect writes nothing.
- R4: A processor-strobe start (`cpu_stb_n`=0 with `sel1_n`=0) is always a read, whatever the write controls show. `sel1_n`=1 masks the processor strobe.
- R5: A controller-strobe start (`ctl_stb_n`=0, processor strobe not taken) is a write when the write qualifier of R6 is true, and a read otherwise.
- R6: `wr_all_n`=0 writes all four lanes. Otherwise, with `wr_byte_n`=0, each lane i whose `lane_n[i]`=0 is written, and lane i is `wdata` bits [8i+7:8i]. When no lane is selected, the cycle is a read.
- R7: In the cycle after a write edge, `rdata_en`=0. In the cycle after a read edge, all 32 bits of `rdata` carry the stored word.
- R8: Flow-through timing: the word at the address registered at an edge appears on `rdata` before the next edge.
- R9: `oe_n`=1 forces `rdata_en`=0 at once, without waiting for a clock edge. `oe_n`=0 enables output only in read cycles.
- R10: On an unstrobed edge during a burst, `adv_n`=0 advances the burst counter, and upper address bits stay fixed. With `interleave`=0 the low two bits are start+n mod 4; with `interleave`=1 they are start XOR n. The counter wraps to the start address on the fifth access.
- R11: On an unstrobed edge during a burst, `adv_n`=1 repeats the current address (suspend).
- R12: At an edge where `sleep`=1 there is no access and outputs are off in the following cycle. Memory contents are kept.
- R13: The first `WAKE_CYC` edges with `sleep`=0 after a sleep are ignored: no write and no read. The block then starts deselected.
- R14: An unstrobed edge while the block is deselected performs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel1_n | input | 1 | Chip select 1, active low; also masks the processor strobe |
| sel2 | input | 1 | Chip select 2, active high, sampled only with a strobe |
| sel3_n | input | 1 | Chip select 3, active low, sampled only with a strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low, always starts a read |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Per-lane write qualifier, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request, active high |
| addr | input | ADDR_W | External word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_en | output | 1 | High when the read bus is driven |

## Verification
The bench runs single accesses started by each strobe with every write-control mix. These include global write, several partial lane masks and an empty mask, which separates the processor-strobe and controller-strobe rules from the lane-merge logic. Linear and interleaved bursts start from an unaligned address and run past four accesses, so any error in the sequence formula, in the wrap or in an upper-bit carry shows up. Suspends, continuations with the secondary selects deasserted, continuations while deselected, and mid-cycle toggling of the output enable separate the strobe-qualified select sampling from the asynchronous output gating. A sleep with write attempts during standby and during the recovery window, followed by read-back, shows whether the ignore window is exactly `WAKE_CYC` edges long and whether contents are kept.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [2:0] {
        S_DESEL,
        S_RD_FIRST,
        S_WR_FIRST,
        S_RD_BURST,
        S_WR_BURST,
        S_SLEEP,
        S_WAKE
    } fts_state_e;

    typedef enum logic [1:0] {
        C_DESEL,
        C_BEGIN,
        C_ADVANCE,
        C_HOLD
    } fts_cyc_e;

    // Low two address bits of the n-th burst access from a start value.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] n,
                                             input logic       ilv);
        return ilv ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/fts_cmd_decode.sv
module fts_cmd_decode
    import fts_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             burst_live,
    output fts_cyc_e         cyc,
    output logic             is_wr,
    output logic [LANES-1:0] lane_we
);

    logic [LANES-1:0] lane_req;
    logic             full_sel;

    always_comb begin
        if (!wr_all_n)       lane_req = '1;
        else if (!wr_byte_n) lane_req = ~lane_n;
        else                 lane_req = '0;
    end

    assign full_sel = !sel1_n && sel2 && !sel3_n;

    always_comb begin
        cyc   = C_DESEL;
        is_wr = 1'b0;
        if (!cpu_stb_n && !sel1_n) begin
            // processor start: never a write
            cyc = full_sel ? C_BEGIN : C_DESEL;
        end else if (!ctl_stb_n) begin
            cyc   = full_sel ? C_BEGIN : C_DESEL;
            is_wr = full_sel && (|lane_req);
        end else if (burst_live) begin
            cyc   = adv_n ? C_HOLD : C_ADVANCE;
            is_wr = |lane_req;
        end
    end

    assign lane_we = is_wr ? lane_req : '0;

endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq
    import fts_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              load,
    input  logic              step,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        ofs_q;
    logic [1:0]        ofs_nxt;

    assign ofs_nxt = step ? ofs_q + 2'd1 : ofs_q;

    always_comb begin
        if (load) acc_addr = ext_addr;
        else      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], ofs_nxt, ilv)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ofs_q  <= '0;
        end else if (commit) begin
            if (load) begin
                base_q <= ext_addr;
                ofs_q  <= '0;
            end else begin
                ofs_q  <= ofs_nxt;
            end
        end
    end

endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
    end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LANES    = 4,
    parameter int LANE_W   = 8,
    parameter int WAKE_CYC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    cpu_stb_n,
    input  logic                    ctl_stb_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    interleave,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int CNT_W  = $clog2(WAKE_CYC + 1);

    fts_state_e        state_q, state_nxt;
    logic [CNT_W-1:0]  wake_q, wake_nxt;
    logic [ADDR_W-1:0] rd_addr_q;

    fts_cyc_e          cyc;
    logic              is_wr;
    logic [LANES-1:0]  lane_we_dec;
    logic [LANES-1:0]  lane_we_acc;
    logic              burst_live;
    logic              accept;
    logic              commit;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] arr_rdata;
    logic              rd_cycle;

    assign burst_live = (state_q == S_RD_FIRST) || (state_q == S_WR_FIRST) ||
                        (state_q == S_RD_BURST) || (state_q == S_WR_BURST);
    assign accept     = !sleep && (burst_live || state_q == S_DESEL);
    assign commit     = accept && (cyc != C_DESEL);
    assign lane_we_acc = accept ? lane_we_dec : '0;

    fts_cmd_decode #(.LANES(LANES)) u_dec (
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .cpu_stb_n  (cpu_stb_n),
        .ctl_stb_n  (ctl_stb_n),
        .adv_n      (adv_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .lane_n     (lane_n),
        .burst_live (burst_live),
        .cyc        (cyc),
        .is_wr      (is_wr),
        .lane_we    (lane_we_dec)
    );

    fts_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .load     (cyc == C_BEGIN),
        .step     (cyc == C_ADVANCE),
        .ilv      (interleave),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk   (clk),
        .we    (lane_we_acc),
        .waddr (acc_addr),
        .wdata (wdata),
        .raddr (rd_addr_q),
        .rdata (arr_rdata)
    );

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        wake_nxt  = wake_q;
        if (sleep) begin
            state_nxt = S_SLEEP;
        end else begin
            unique case (state_q)
                S_SLEEP: begin
                    if (WAKE_CYC > 1) begin
                        state_nxt = S_WAKE;
                        wake_nxt  = CNT_W'(WAKE_CYC - 1);
                    end else begin
                        state_nxt = S_DESEL;
                    end
                end
                S_WAKE: begin
                    wake_nxt = wake_q - CNT_W'(1);
                    if (wake_q <= CNT_W'(1)) state_nxt = S_DESEL;
                end
                S_DESEL, S_RD_FIRST, S_WR_FIRST, S_RD_BURST, S_WR_BURST: begin
                    unique case (cyc)
                        C_DESEL:   state_nxt = S_DESEL;
                        C_BEGIN:   state_nxt = is_wr ? S_WR_FIRST : S_RD_FIRST;
                        C_ADVANCE,
                        C_HOLD:    state_nxt = is_wr ? S_WR_BURST : S_RD_BURST;
                        default:   state_nxt = S_DESEL;
                    endcase
                end
                default: state_nxt = S_DESEL;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_DESEL;
            wake_q    <= '0;
            rd_addr_q <= '0;
        end else begin
            state_q <= state_nxt;
            wake_q  <= wake_nxt;
            if (commit && !is_wr) rd_addr_q <= acc_addr;
        end
    end

    // outputs
    always_comb begin
        rd_cycle = (state_q == S_RD_FIRST) || (state_q == S_RD_BURST);
        rdata_en = rd_cycle && !oe_n;
        rdata    = rdata_en ? arr_rdata : '0;
    end

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
    parameter int LANES    = 4,
    parameter int WAKE_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel1_n,
    input logic             sel2,
    input logic             sel3_n,
    input logic             cpu_stb_n,
    input logic             ctl_stb_n,
    input logic             oe_n,
    input logic             sleep,
    input logic             rdata_en,
    input logic [LANES-1:0] arr_we
);

    localparam int CW = $clog2(WAKE_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          quiet;
    logic          full_sel;
    logic          strobed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (sleep) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && cnt_q < CW'(WAKE_CYC)) begin
            cnt_q   <= cnt_q + CW'(1);
        end
    end

    assign quiet    = sleep || (armed_q && cnt_q < CW'(WAKE_CYC));
    assign full_sel = !sel1_n && sel2 && !sel3_n;
    assign strobed  = (!cpu_stb_n && !sel1_n) || !ctl_stb_n;

    assert_desel_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobed && !full_sel) |-> (arr_we == '0))
        else $error("deselect wrote the array");

    assert_desel_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet && strobed && !full_sel) |=> !rdata_en)
        else $error("output driven after deselect");

    assert_cpu_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !sel1_n) |-> (arr_we == '0))
        else $error("processor strobe start wrote");

    assert_cpu_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet && !cpu_stb_n && full_sel) |=> (oe_n || rdata_en))
        else $error("processor strobe start did not read");

    assert_write_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|arr_we) |=> !rdata_en)
        else $error("output driven during write");

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_en)
        else $error("output driven with oe_n high");

    assert_sleep_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !rdata_en)
        else $error("output driven after sleep edge");

    assert_wake_nowrite_R13: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (arr_we == '0))
        else $error("write during sleep or recovery");

    assert_wake_noread_R13: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !rdata_en)
        else $error("read during sleep or recovery");

endmodule

bind fts_sram fts_sram_chk #(.LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .rdata_en  (rdata_en),
    .arr_we    (lane_we_acc)
);

// File: tb/tb_fts_sram.sv
`timescale 1ns/1ps
module tb_fts_sram;

    localparam int WAKE = 4;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic        cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, adv_n = 1'b1;
    logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0]  lane_n = 4'hF;
    logic        interleave = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdata_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_mem [DEPTH];
    bit m_live = 0, m_rd = 0;
    int m_rdaddr = 0, m_base = 0, m_ofs = 0, m_wake = 0;

    always #2.5 clk = ~clk;

    fts_sram dut (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
        .interleave(interleave), .oe_n(oe_n), .sleep(sleep), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    function automatic logic [31:0] patt(int i);
        return 32'h1357_9BDF ^ (i * 32'h0103_0507);
    endfunction

    task automatic model_edge();
        logic [3:0] mask;
        bit full, access, wr;
        int acc;
        mask = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_n : 4'h0);
        if (sleep) begin m_wake = WAKE; m_rd = 0; m_live = 0; return; end
        if (m_wake > 0) begin m_wake--; m_rd = 0; m_live = 0; return; end
        full = !sel1_n && sel2 && !sel3_n;
        access = 1; wr = 0;
        if (!cpu_stb_n && !sel1_n) begin
            if (full) begin m_base = addr; m_ofs = 0; end else access = 0;
        end else if (!ctl_stb_n) begin
            if (full) begin m_base = addr; m_ofs = 0; wr = (mask != 0); end else access = 0;
        end else if (m_live) begin
            if (!adv_n) m_ofs = (m_ofs + 1) % 4;
            wr = (mask != 0);
        end else access = 0;
        if (!access) begin m_live = 0; m_rd = 0; return; end
        acc = (m_base & ~3) | (interleave ? ((m_base & 3) ^ m_ofs) : (((m_base & 3) + m_ofs) % 4));
        m_live = 1;
        if (wr) begin
            for (int k = 0; k < 4; k++) if (mask[k]) m_mem[acc][8*k +: 8] = wdata[8*k +: 8];
            m_rd = 0;
        end else begin
            m_rd = 1; m_rdaddr = acc;
        end
    endtask

    task automatic cmp(string tag);
        bit e_en;
        logic [31:0] e_d;
        e_en = m_rd && !oe_n;
        e_d  = e_en ? m_mem[m_rdaddr] : 32'h0;
        n_cmp++;
        if (rdata_en !== e_en || rdata !== e_d) begin
            n_bad++;
            $display("FAIL %s: en=%0b data=%h, expected en=%0b data=%h", tag, rdata_en, rdata, e_en, e_d);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        model_edge();
        #1;
        cmp(tag);
    endtask

    task automatic go(string tag, bit c_n, bit k_n, bit v_n, bit g_n, bit b_n,
                      logic [3:0] ln, int ad, logic [31:0] d);
        cpu_stb_n = c_n; ctl_stb_n = k_n; adv_n = v_n;
        wr_all_n = g_n; wr_byte_n = b_n; lane_n = ln;
        addr = 6'(ad); wdata = d;
        tick(tag);
    endtask

    task automatic rd(string tag, int ad);
        go(tag, 1, 0, 1, 1, 1, 4'hF, ad, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp("R3 reset");

        // fill with global writes via controller strobe
        for (int i = 0; i < DEPTH; i++) go("R5 fill", 1, 0, 1, 0, 1, 4'hF, i, patt(i));
        // single flow-through reads
        rd("R8 read", 0); rd("R8 read", 5); rd("R7 read", 63);
        // processor strobe with all write controls active is still a read
        go("R4 cpu", 0, 1, 1, 0, 0, 4'h0, 9, 32'hDEAD_BEEF);
        rd("R4 readback", 9);
        // sel1_n high masks processor strobe; controller strobe then deselects
        sel1_n = 1'b1;
        go("R4 masked", 0, 0, 1, 0, 1, 4'hF, 10, 32'hBAD0_BAD0);
        sel1_n = 1'b0;
        rd("R1 readback", 10);
        // byte lane writes
        go("R6 lane0", 1, 0, 1, 1, 0, 4'b1110, 12, 32'h1122_3344);
        rd("R6 lane0 rd", 12);
        go("R6 lanes13", 1, 0, 1, 1, 0, 4'b0101, 12, 32'hAABB_CCDD);
        rd("R6 lanes13 rd", 12);
        go("R6 nolane", 1, 0, 1, 1, 0, 4'hF, 12, 32'h5555_5555);
        go("R7 all", 1, 0, 1, 0, 1, 4'hF, 13, 32'h0F0F_F0F0);
        rd("R6 all rd", 13);
        // linear burst from unaligned start, past the wrap
        interleave = 1'b0;
        rd("R10 lin", 6);
        for (int k = 0; k < 5; k++) go("R10 lin adv", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        // interleaved burst
        interleave = 1'b1;
        rd("R10 ilv", 7);
        for (int k = 0; k < 5; k++) go("R10 ilv adv", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        // burst write then burst read
        interleave = 1'b0;
        go("R10 wr", 1, 0, 1, 0, 1, 4'hF, 21, 32'hA0A0_0001);
        for (int k = 0; k < 3; k++) go("R10 wr adv", 1, 1, 0, 0, 1, 4'hF, 0, 32'hA0A0_0010 + k);
        rd("R10 rdb", 20);
        for (int k = 0; k < 3; k++) go("R10 rdb adv", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        // suspend
        rd("R11 start", 33);
        go("R11 hold", 1, 1, 1, 1, 1, 4'hF, 0, 0);
        go("R11 hold", 1, 1, 1, 1, 1, 4'hF, 0, 0);
        go("R11 adv", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        go("R11 hold", 1, 1, 1, 1, 1, 4'hF, 0, 0);
        // secondary selects ignored without strobe
        rd("R2 start", 40);
        sel2 = 1'b0; sel3_n = 1'b1;
        go("R2 cont", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        go("R2 cont", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        // strobed with bad selects: deselect
        go("R1 cpu desel", 0, 1, 1, 1, 1, 4'hF, 41, 0);
        sel2 = 1'b1;
        go("R1 ctl desel", 1, 0, 1, 0, 1, 4'hF, 42, 32'hBAD1_BAD1);
        sel3_n = 1'b0;
        rd("R3 readback", 42);
        // continuation while deselected
        sel2 = 1'b0;
        go("R3 desel", 1, 0, 1, 1, 1, 4'hF, 0, 0);
        sel2 = 1'b1;
        go("R14 idle cont", 1, 1, 0, 0, 1, 4'hF, 50, 32'hBAD2_BAD2);
        rd("R14 readback", 50);
        // asynchronous output enable
        oe_n = 1'b1;
        rd("R9 oe high", 3);
        oe_n = 1'b0; #1 cmp("R9 oe low async");
        oe_n = 1'b1; #1 cmp("R9 oe high async");
        oe_n = 1'b0;
        go("R9 write", 1, 0, 1, 0, 1, 4'hF, 4, 32'h4444_0000);
        oe_n = 1'b0; #1 cmp("R9 oe low on write");
        // sleep and recovery
        rd("R12 pre", 5);
        sleep = 1'b1;
        for (int k = 0; k < 3; k++) go("R12 sleep", 1, 0, 1, 0, 1, 4'hF, 5, 32'hBAD3_BAD3);
        sleep = 1'b0;
        for (int k = 0; k < WAKE; k++) go("R13 recov", 1, 0, 1, 0, 1, 4'hF, 5, 32'hBAD4_BAD4);
        go("R13 after", 1, 1, 0, 1, 1, 4'hF, 0, 0);
        rd("R12 retained", 5);
        go("R13 write ok", 1, 0, 1, 0, 1, 4'hF, 5, 32'h5A5A_A5A5);
        rd("R13 readback", 5);
        go("R3 idle", 1, 1, 1, 1, 1, 4'hF, 0, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule